// File: doc/BRIEF.md
# Conditional Sum Adder

This is a purely combinational adder of parameterised width that finds its carries by selection rather than by ripple. Every bit position first forms two results at once: one that assumes no carry arrives from below, and one that assumes a carry does arrive. Neighbouring blocks are then paired level by level. The carry of the lower block, under each assumption, chooses which of the upper block's two results to keep. The block width doubles and the number of blocks halves at every level until one full-width pair of candidates is left. The true carry input then picks one of those two.

The width must be a power of two, at least 2. The structure has log2(WIDTH) merge levels above the one-bit leaves. A width that is not a power of two stops elaboration with an error. The adder is used wherever a short, regular carry path is worth the cost of duplicating every result.

Top module: `csum_adder`

## Requirements
- R1: For every x, y and cin, {cout, sum} equals x + y + cin, taken as unsigned numbers one bit wider than the operands.
- R2: sum bit 0 equals x[0] XOR y[0] XOR cin.
- R3: When every bit position propagates (x XOR y all ones), cout equals cin and every sum bit equals NOT cin.
- R4: When the top bits of x and y are both 1, cout is 1 whatever the other inputs are.
- R5: When the top bits of x and y are both 0, cout is 0 whatever the other inputs are.
- R6: With y all zeros and cin 0, sum equals x and cout is 0.
- R7: sum bits [i:0] depend only on x[i:0], y[i:0] and cin. Changing higher operand bits leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | WIDTH | First operand |
| y | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The two functions that meet in the same evaluation are the final carry-in selection and the lower-half carry selections at every merge level. Both decide the result of one vector together. The clearest case is an all-propagate operand pair, where only cin can set the outcome. Another is a carry generated at bit 0 that must pass through every level of multiplexers. These vectors are applied with cin both 0 and 1 and judged against the arithmetic sum, alongside an exhaustive sweep of a 4-bit instance and random vectors on a 16-bit one.

// File: rtl/csa_pkg.sv
package csa_pkg;
    function automatic bit is_pow2(input int n);
        return (n >= 2) && ((n & (n - 1)) == 0);
    endfunction
endpackage

// File: rtl/csa_leaf.sv
// One-bit block: results for an assumed carry-in of 0 and of 1.
module csa_leaf (
    input  logic a,
    input  logic b,
    output logic s0,
    output logic c0,
    output logic s1,
    output logic c1
);
    always_comb begin
        s0 = a ^ b;
        c0 = a & b;
        s1 = ~(a ^ b);
        c1 = a | b;
    end
endmodule

// File: rtl/csa_merge.sv
// Joins two W-bit candidate pairs into one 2W-bit candidate pair.
module csa_merge #(
    parameter int W = 1
) (
    input  logic [W-1:0]   lo_s0,
    input  logic [W-1:0]   lo_s1,
    input  logic           lo_c0,
    input  logic           lo_c1,
    input  logic [W-1:0]   hi_s0,
    input  logic [W-1:0]   hi_s1,
    input  logic           hi_c0,
    input  logic           hi_c1,
    output logic [2*W-1:0] m_s0,
    output logic [2*W-1:0] m_s1,
    output logic           m_c0,
    output logic           m_c1
);
    always_comb begin
        // assumption "carry-in 0": lower carry picks the upper candidate
        m_s0 = lo_c0 ? {hi_s1, lo_s0} : {hi_s0, lo_s0};
        m_c0 = lo_c0 ? hi_c1 : hi_c0;
        // assumption "carry-in 1"
        m_s1 = lo_c1 ? {hi_s1, lo_s1} : {hi_s0, lo_s1};
        m_c1 = lo_c1 ? hi_c1 : hi_c0;
    end
endmodule

// File: rtl/csa_pick.sv
// Final choice between the two full-width candidates.
module csa_pick #(
    parameter int W = 16
) (
    input  logic [W-1:0] s0,
    input  logic [W-1:0] s1,
    input  logic         c0,
    input  logic         c1,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    always_comb begin
        sum  = cin ? s1 : s0;
        cout = cin ? c1 : c0;
    end
endmodule

// File: rtl/csum_adder.sv
module csum_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    import csa_pkg::*;

    localparam int LEVELS = $clog2(WIDTH);

    if (!is_pow2(WIDTH)) begin : g_bad_width
        $error("csum_adder: WIDTH must be a power of two, at least 2");
    end

    for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
        localparam int NB = WIDTH >> lv;
        localparam int BW = 1 << lv;
        logic [WIDTH-1:0] s0;
        logic [WIDTH-1:0] s1;
        logic [NB-1:0]    c0;
        logic [NB-1:0]    c1;

        if (lv == 0) begin : g_leaf
            for (genvar b = 0; b < WIDTH; b++) begin : g_bit
                csa_leaf u_leaf (
                    .a  (x[b]),
                    .b  (y[b]),
                    .s0 (s0[b]),
                    .c0 (c0[b]),
                    .s1 (s1[b]),
                    .c1 (c1[b])
                );
            end
        end else begin : g_join
            for (genvar b = 0; b < NB; b++) begin : g_blk
                csa_merge #(.W(BW / 2)) u_mrg (
                    .lo_s0 (g_lvl[lv-1].s0[b*BW +: BW/2]),
                    .lo_s1 (g_lvl[lv-1].s1[b*BW +: BW/2]),
                    .lo_c0 (g_lvl[lv-1].c0[2*b]),
                    .lo_c1 (g_lvl[lv-1].c1[2*b]),
                    .hi_s0 (g_lvl[lv-1].s0[b*BW + BW/2 +: BW/2]),
                    .hi_s1 (g_lvl[lv-1].s1[b*BW + BW/2 +: BW/2]),
                    .hi_c0 (g_lvl[lv-1].c0[2*b+1]),
                    .hi_c1 (g_lvl[lv-1].c1[2*b+1]),
                    .m_s0  (s0[b*BW +: BW]),
                    .m_s1  (s1[b*BW +: BW]),
                    .m_c0  (c0[b]),
                    .m_c1  (c1[b])
                );
            end
        end
    end

    csa_pick #(.W(WIDTH)) u_pick (
        .s0   (g_lvl[LEVELS].s0),
        .s1   (g_lvl[LEVELS].s1),
        .c0   (g_lvl[LEVELS].c0[0]),
        .c1   (g_lvl[LEVELS].c1[0]),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );
endmodule

// File: rtl/csum_adder_chk.sv
module csum_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] x,
    input logic [WIDTH-1:0] y,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout
);
    always_comb begin
        assert_total_R1: assert ({cout, sum} == ({1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin}));
        assert_lsb_R2: assert (sum[0] == (x[0] ^ y[0] ^ cin));
        if ((x ^ y) == {WIDTH{1'b1}}) begin
            assert_propagate_R3: assert (cout == cin && sum == {WIDTH{~cin}});
        end
        if (x[WIDTH-1] && y[WIDTH-1]) begin
            assert_generate_R4: assert (cout);
        end
        if (!x[WIDTH-1] && !y[WIDTH-1]) begin
            assert_kill_R5: assert (!cout);
        end
        if (y == '0 && !cin) begin
            assert_identity_R6: assert (sum == x && !cout);
        end
    end
endmodule

bind csum_adder csum_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .x    (x),
    .y    (y),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
);

// File: tb/csum_adder_tb.sv
module csum_adder_tb;
    localparam int W16 = 16;
    localparam int W4  = 4;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [W16-1:0] x16 = '0, y16 = '0, s16;
    logic           ci16 = 1'b0, co16;
    logic [W4-1:0]  x4 = '0, y4 = '0, s4;
    logic           ci4 = 1'b0, co4;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    csum_adder #(.WIDTH(W16)) u_dut (
        .x(x16), .y(y16), .cin(ci16), .sum(s16), .cout(co16)
    );
    csum_adder #(.WIDTH(W4)) u_dut4 (
        .x(x4), .y(y4), .cin(ci4), .sum(s4), .cout(co4)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive16(input logic [15:0] a, input logic [15:0] b, input logic c);
        @(negedge clk);
        x16 = a; y16 = b; ci16 = c;
        #5;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
        finish_run();
    end

    initial begin
        logic [15:0] keep;
        logic [15:0] ra, rb;
        logic        rc;
        logic [16:0] exp17;

        // reset state: all inputs zero (R6)
        @(negedge clk); #5;
        check("R6 zero inputs sum", {16'h0, s16}, 32'h0);
        check("R6 zero inputs cout", {31'h0, co16}, 32'h0);

        // R1/R2: exhaustive 4-bit sweep
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int c = 0; c < 2; c++) begin
                    @(negedge clk);
                    x4 = a[3:0]; y4 = b[3:0]; ci4 = c[0];
                    #5;
                    check("R1 4-bit total", {27'h0, co4, s4}, a + b + c);
                    check("R2 4-bit lsb", {31'h0, s4[0]}, {31'h0, a[0] ^ b[0] ^ c[0]});
                end
            end
        end

        // R3: full propagate, cin decides everything
        for (int c = 0; c < 2; c++) begin
            drive16(16'hAAAA, 16'h5555, c[0]);
            check("R3 propagate cout", {31'h0, co16}, {31'h0, c[0]});
            check("R3 propagate sum", {16'h0, s16}, {16'h0, {16{~c[0]}}});
        end
        drive16(16'h0F0F, 16'hF0F0, 1'b1);
        check("R3 propagate mixed sum", {16'h0, s16}, 32'h0);

        // R4: generate at top bit
        drive16(16'h8000, 16'h8000, 1'b0);
        check("R4 top generate cout", {31'h0, co16}, 32'h1);
        drive16(16'hFFFF, 16'h8000, 1'b1);
        check("R4 top generate cout cin1", {31'h0, co16}, 32'h1);

        // R5: kill at top bit
        drive16(16'h7FFF, 16'h0000, 1'b1);
        check("R5 top kill cout", {31'h0, co16}, 32'h0);
        check("R5 top kill sum", {16'h0, s16}, 32'h8000);

        // R1: carry from bit 0 through every merge level
        drive16(16'hFFFF, 16'h0001, 1'b0);
        check("R1 long carry", {15'h0, co16, s16}, 32'h10000);
        drive16(16'hFFFF, 16'hFFFF, 1'b1);
        check("R1 max operands", {15'h0, co16, s16}, 32'h1FFFF);

        // R6: identity with nonzero x
        drive16(16'hBEEF, 16'h0000, 1'b0);
        check("R6 identity", {15'h0, co16, s16}, 32'h0BEEF);

        // R1/R2: random vectors at 16 bits
        for (int i = 0; i < 3000; i++) begin
            ra = 16'($urandom); rb = 16'($urandom); rc = 1'($urandom);
            drive16(ra, rb, rc);
            exp17 = {1'b0, ra} + {1'b0, rb} + {16'h0, rc};
            check("R1 random total", {15'h0, co16, s16}, {15'h0, exp17});
            check("R2 random lsb", {31'h0, s16[0]}, {31'h0, ra[0] ^ rb[0] ^ rc});
        end

        // R7: higher operand bits do not disturb lower sum bits
        for (int i = 0; i < 200; i++) begin
            ra = 16'($urandom); rb = 16'($urandom); rc = 1'($urandom);
            drive16(ra, rb, rc);
            keep = s16;
            drive16({8'($urandom), ra[7:0]}, {8'($urandom), rb[7:0]}, rc);
            check("R7 lower bits stable", {24'h0, s16[7:0]}, {24'h0, keep[7:0]});
        end

        finish_run();
    end
endmodule